// File: doc/BRIEF.md
# Serial-Clocked Successive-Approximation Sequencer

This block is the digital half of a 10-bit successive-approximation converter whose conversion steps are paced by an external serial clock rather than an internal oscillator. A host pulls the active-low select line low to freeze the input sample and start a conversion. After that, every rising edge of the serial clock either shifts out a framing zero or resolves one more result bit. The block drives that bit onto a serial data line with an output enable, so a pad can float the line while the block is not selected.

The block drives a trial code to an external weighting network and reads back a single comparator bit, which reports whether the held sample is at or above the trial level. Ten data bits come out most significant first in straight binary. Two sub-LSB refinement bits follow them, and then zeros for as long as the host keeps clocking. An active-low power-down input stops all activity. After power-down is released, and after reset, a programmable settling interval must pass before a new conversion is accepted. All inputs are sampled on the system clock. Serial-clock edges and select edges are detected from those samples.

Top module: `sar_serial_conv`

## Requirements
- R1: A falling edge of `csel_n`, seen while the block is powered and settled, starts a conversion. One clock later `sdo_en` is 1, `sdo` is 0, `sample_hold` is 1 and `dac_code` is midscale (12'h800, only bit 11 set).
- R2: While `csel_n` is high, `sdo_en` is 0 from the following clock onward.
- R3: `sdo` changes only in the clock after a detected `sclk` rising edge, a detected `csel_n` falling edge, or power-down.
- R4: The first two `sclk` rising edges of a conversion drive `sdo` to 0. The third drives the result MSB.
- R5: On edges 3 to 12, `sdo` carries result bits 9 down to 0 in straight binary. Each bit is decided by the rule: keep the trial bit if `cmp_ge` is 1, else clear it, then set the next lower bit as the new trial.
- R6: Edges 13 and 14 carry the two sub-bits, high one first, produced by the same compare rule. The final 12-bit `dac_code` equals the held sample.
- R7: After edge 14, `sample_hold` is 0. Every further edge while `csel_n` stays low drives `sdo` to 0 and leaves `dac_code` unchanged.
- R8: Raising `csel_n` during a conversion aborts it. On the next clock `sdo_en` and `sample_hold` are 0, and the next conversion starts again from midscale.
- R9: While `pd_n` is 0, `sdo_en` and `sample_hold` are 0 and `csel_n` falling edges are ignored.
- R10: For WAKE_CYC clocks after `pd_n` rises or after reset, a `csel_n` falling edge starts nothing. A falling edge after that interval starts a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| csel_n | input | 1 | Active-low select; a falling edge starts a conversion and a rising edge ends or aborts it |
| sclk | input | 1 | Serial clock; each rising edge advances the conversion by one step |
| pd_n | input | 1 | Active-low power-down |
| cmp_ge | input | 1 | Comparator result: held sample at or above `dac_code` |
| dac_code | output | 12 | Current trial code for the weighting network |
| sample_hold | output | 1 | 1 while the sample is held for conversion |
| sdo | output | 1 | Serial result data |
| sdo_en | output | 1 | Output enable for the serial data pad (0 = high impedance) |

## Verification
The hardest states to reach from the ports are the ones that interrupt a frame partway. These are a select rising edge in the middle of resolution, power-down while bits are being produced, and a select falling edge that lands inside the settling window after power-down is released.

The stimulus stops a frame after a fixed number of serial edges, then checks that the following frame restarts cleanly from midscale with a correct code. It also drops select a few clocks after power-down is released and confirms that the data line stays floating. The comparator is modelled in the bench as a compare of a chosen 12-bit sample against `dac_code`. The table therefore covers extreme codes, alternating patterns and each sub-bit value.

// File: rtl/sar_serial_pkg.sv
package sar_serial_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_CONV = 2'd2,
    PH_TAIL = 2'd3
  } phase_t;
endpackage

// File: rtl/sar_edge_detect.sv
module sar_edge_detect #(
  parameter int              WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= RST_VAL;
    else     prev <= din;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign rise[g] = din[g] & ~prev[g];
    assign fall[g] = ~din[g] & prev[g];
  end
endmodule

// File: rtl/sar_wake_timer.sv
module sar_wake_timer #(
  parameter int WAKE_CYC = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic pd_n,
  output logic awake
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  logic [CW-1:0] cnt;

  assign awake = (cnt == CW'(WAKE_CYC));

  always_ff @(posedge clk) begin
    if (rst || !pd_n) cnt <= '0;
    else if (!awake)  cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/sar_trial_core.sv
module sar_trial_core #(
  parameter int NBITS = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             step,
  input  logic             abort,
  input  logic             cmp_ge,
  output logic [NBITS-1:0] trial,
  output logic             busy,
  output logic             last
);
  localparam int              PW  = $clog2(NBITS);
  localparam logic [NBITS-1:0] MID = NBITS'(1) << (NBITS - 1);

  logic [PW-1:0] ptr;

  assign last = busy && (ptr == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      trial <= '0;
      ptr   <= '0;
      busy  <= 1'b0;
    end else if (abort) begin
      busy  <= 1'b0;
      ptr   <= '0;
    end else if (start) begin
      trial <= MID;
      ptr   <= PW'(NBITS - 1);
      busy  <= 1'b1;
    end else if (step && busy) begin
      trial[ptr] <= cmp_ge;
      if (ptr != '0) begin
        trial[ptr - PW'(1)] <= 1'b1;
        ptr <= ptr - PW'(1);
      end else begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sar_serial_conv.sv
module sar_serial_conv #(
  parameter int RES_BITS   = 10,
  parameter int SUB_BITS   = 2,
  parameter int LEAD_ZEROS = 2,
  parameter int WAKE_CYC   = 256,
  localparam int NBITS     = RES_BITS + SUB_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csel_n,
  input  logic             sclk,
  input  logic             pd_n,
  input  logic             cmp_ge,
  output logic [NBITS-1:0] dac_code,
  output logic             sample_hold,
  output logic             sdo,
  output logic             sdo_en
);
  import sar_serial_pkg::*;

  localparam int LW = $clog2(LEAD_ZEROS + 1);

  logic [1:0] ev_rise, ev_fall;
  logic       sclk_rise, cs_fall, cs_rise, awake;
  logic       core_start, core_step, core_abort, core_busy, core_last;
  phase_t     phase;
  logic [LW-1:0] lead_cnt;

  sar_edge_detect #(.WIDTH(2), .RST_VAL(2'b10)) u_edges (
    .clk  (clk),
    .rst  (rst),
    .din  ({csel_n, sclk}),
    .rise (ev_rise),
    .fall (ev_fall)
  );

  assign sclk_rise = ev_rise[0];
  assign cs_rise   = ev_rise[1];
  assign cs_fall   = ev_fall[1];

  sar_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk   (clk),
    .rst   (rst),
    .pd_n  (pd_n),
    .awake (awake)
  );

  assign core_abort = !pd_n || cs_rise;
  assign core_start = pd_n && !cs_rise && cs_fall && awake;
  assign core_step  = pd_n && !cs_rise && !cs_fall && sclk_rise && (phase == PH_CONV);

  sar_trial_core #(.NBITS(NBITS)) u_core (
    .clk    (clk),
    .rst    (rst),
    .start  (core_start),
    .step   (core_step),
    .abort  (core_abort),
    .cmp_ge (cmp_ge),
    .trial  (dac_code),
    .busy   (core_busy),
    .last   (core_last)
  );

  always_ff @(posedge clk) begin
    if (rst || !pd_n) begin
      phase       <= PH_IDLE;
      lead_cnt    <= '0;
      sdo         <= 1'b0;
      sdo_en      <= 1'b0;
      sample_hold <= 1'b0;
    end else if (cs_rise) begin
      phase       <= PH_IDLE;
      lead_cnt    <= '0;
      sdo_en      <= 1'b0;
      sample_hold <= 1'b0;
    end else if (core_start) begin
      phase       <= PH_LEAD;
      lead_cnt    <= '0;
      sdo         <= 1'b0;
      sdo_en      <= 1'b1;
      sample_hold <= 1'b1;
    end else if (sclk_rise && phase != PH_IDLE) begin
      case (phase)
        PH_LEAD: begin
          sdo      <= 1'b0;
          lead_cnt <= lead_cnt + LW'(1);
          if (lead_cnt == LW'(LEAD_ZEROS - 1)) phase <= PH_CONV;
        end
        PH_CONV: begin
          sdo <= cmp_ge;
          if (core_last || !core_busy) begin
            phase       <= PH_TAIL;
            sample_hold <= 1'b0;
          end
        end
        default: sdo <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sar_serial_conv_chk.sv
module sar_serial_conv_chk #(
  parameter int NBITS = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             csel_n,
  input logic             pd_n,
  input logic [NBITS-1:0] dac_code,
  input logic             sample_hold,
  input logic             sdo,
  input logic             sdo_en,
  input logic             sclk_rise,
  input logic             cs_fall,
  input logic             cs_rise,
  input logic             awake
);
  localparam logic [NBITS-1:0] MID = NBITS'(1) << (NBITS - 1);

  a_r1_start_state: assert property (@(posedge clk) disable iff (rst)
    (cs_fall && awake && pd_n) |=> (sdo_en && !sdo && sample_hold && dac_code == MID));

  a_r2_float_when_deselected: assert property (@(posedge clk) disable iff (rst)
    $past(csel_n) |-> !sdo_en);

  a_r3_sdo_moves_on_edges: assert property (@(posedge clk) disable iff (rst)
    (!sclk_rise && !cs_fall && pd_n) |=> $stable(sdo));

  a_r7_code_frozen: assert property (@(posedge clk) disable iff (rst)
    (!sample_hold && !cs_fall) |=> $stable(dac_code));

  a_r8_abort: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> (!sdo_en && !sample_hold));

  a_r9_powerdown: assert property (@(posedge clk) disable iff (rst)
    !pd_n |=> (!sdo_en && !sample_hold));
endmodule

bind sar_serial_conv sar_serial_conv_chk #(.NBITS(NBITS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .csel_n      (csel_n),
  .pd_n        (pd_n),
  .dac_code    (dac_code),
  .sample_hold (sample_hold),
  .sdo         (sdo),
  .sdo_en      (sdo_en),
  .sclk_rise   (sclk_rise),
  .cs_fall     (cs_fall),
  .cs_rise     (cs_rise),
  .awake       (awake)
);

// File: tb/sar_serial_conv_bench.sv
module sar_serial_conv_bench;
  localparam int WAKE = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csel_n = 1'b1;
  logic        sclk = 1'b0;
  logic        pd_n = 1'b1;
  logic [11:0] sample = '0;
  logic        cmp_ge;
  logic [11:0] dac_code;
  logic        sample_hold, sdo, sdo_en;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  assign cmp_ge = (sample >= dac_code);

  sar_serial_conv u_sar_serial_conv (
    .clk(clk), .rst(rst), .csel_n(csel_n), .sclk(sclk), .pd_n(pd_n),
    .cmp_ge(cmp_ge), .dac_code(dac_code), .sample_hold(sample_hold),
    .sdo(sdo), .sdo_en(sdo_en)
  );

  // {sample, expected data, expected sub-bits}
  localparam logic [23:0] VEC [8] = '{
    {12'h000, 10'h000, 2'd0},
    {12'hFFF, 10'h3FF, 2'd3},
    {12'h800, 10'h200, 2'd0},
    {12'h7FF, 10'h1FF, 2'd3},
    {12'h555, 10'h155, 2'd1},
    {12'hAAA, 10'h2AA, 2'd2},
    {12'h001, 10'h000, 2'd1},
    {12'hC36, 10'h30D, 2'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sclk_edge(output logic v);
    @(negedge clk) sclk = 1'b1;
    @(negedge clk) v = sdo;
    sclk = 1'b0;
    wait_neg(2);
    chk(sdo == v, "R3 sdo held between edges", sdo, v);
  endtask

  task automatic start_conv(input logic [11:0] s);
    sample = s;
    @(negedge clk) csel_n = 1'b0;
    @(negedge clk);
    chk(sdo_en && !sdo && sample_hold, "R1 start state", {sdo_en, sdo, sample_hold}, 3'b101);
    chk(dac_code == 12'h800, "R1/R8 midscale trial", dac_code, 12'h800);
  endtask

  task automatic run_conv(input logic [11:0] s, input logic [9:0] ed, input logic [1:0] es);
    logic       v;
    logic [9:0] got_d;
    logic [1:0] got_s;
    start_conv(s);
    got_d = '0;
    got_s = '0;
    for (int k = 1; k <= 17; k++) begin
      sclk_edge(v);
      if (k <= 2) chk(v == 1'b0, "R4 leading zero", v, 0);
      else if (k <= 12) begin
        got_d[12 - k] = v;
        if (k == 3) chk(v == ed[9], "R4 MSB on third edge", v, ed[9]);
      end else if (k <= 14) got_s[14 - k] = v;
      else chk(v == 1'b0, "R7 trailing zero", v, 0);
      if (k == 12) chk(sample_hold, "R7 hold kept before sub-bits", sample_hold, 1);
      if (k == 14) begin
        chk(!sample_hold, "R7 hold released", sample_hold, 0);
        chk(dac_code == s, "R6 final code", dac_code, s);
      end
    end
    chk(got_d == ed, "R5 data bits", got_d, ed);
    chk(got_s == es, "R6 sub-bits", got_s, es);
    chk(dac_code == s, "R7 code unchanged by extra edges", dac_code, s);
    chk(sdo_en, "R2 driven while selected", sdo_en, 1);
    @(negedge clk) csel_n = 1'b1;
    @(negedge clk);
    chk(!sdo_en, "R2 float after deselect", sdo_en, 0);
    wait_neg(3);
  endtask

  initial begin
    logic v;
    wait_neg(4);
    chk(!sdo_en && !sample_hold && !sdo, "R2 reset state", {sdo_en, sample_hold, sdo}, 0);
    rst = 1'b0;
    wait_neg(10);
    // R10: select inside the settling window after reset is ignored
    @(negedge clk) csel_n = 1'b0;
    wait_neg(2);
    chk(!sdo_en && !sample_hold, "R10 early select ignored", sdo_en, 0);
    csel_n = 1'b1;
    wait_neg(WAKE + 20);

    for (int i = 0; i < 8; i++)
      run_conv(VEC[i][23:12], VEC[i][11:2], VEC[i][1:0]);

    // R8: abort after six edges, then a clean restart
    start_conv(12'h3A5);
    for (int k = 0; k < 6; k++) sclk_edge(v);
    @(negedge clk) csel_n = 1'b1;
    @(negedge clk);
    chk(!sdo_en && !sample_hold, "R8 abort", {sdo_en, sample_hold}, 0);
    wait_neg(3);
    run_conv(12'h2C4, 10'h0B1, 2'd0);

    // R9: power-down in mid-conversion
    start_conv(12'h6E1);
    for (int k = 0; k < 4; k++) sclk_edge(v);
    @(negedge clk) pd_n = 1'b0;
    @(negedge clk);
    chk(!sdo_en && !sample_hold, "R9 power-down stops frame", {sdo_en, sample_hold}, 0);
    csel_n = 1'b1;
    wait_neg(3);
    csel_n = 1'b0;
    wait_neg(2);
    chk(!sdo_en && !sample_hold, "R9 select ignored while down", sdo_en, 0);
    csel_n = 1'b1;
    wait_neg(3);
    // R10: settling window after release
    pd_n = 1'b1;
    wait_neg(5);
    csel_n = 1'b0;
    wait_neg(2);
    chk(!sdo_en, "R10 select during wake ignored", sdo_en, 0);
    csel_n = 1'b1;
    wait_neg(WAKE + 20);
    run_conv(12'h19B, 10'h066, 2'd3);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule